// File: doc/BRIEF.md
# Asynchronous SRAM Write Sequencer

This block turns a single-cycle write request on a clocked interface into one complete write cycle on the pins of a 32K x 8 asynchronous static RAM. It drives the active-low chip-select, write-strobe and read-enable pins, the address bus, and the outgoing data bus with its drive enable. Each minimum interval the memory needs is converted at elaboration time into a whole number of clock cycles. The conversion uses the clock period and the selected speed grade.

The memory stores data only while chip-select and write-strobe are both low. The write ends at whichever of the two rises first. The block chooses that terminating strobe through a parameter and counts the data and address intervals from that edge. Requests arriving while a cycle is in progress are held off by `busy`. Each finished cycle is announced by a one-cycle `done` pulse.

Top module: `sramw_wr`

## Requirements
- R1: While `rst_n` is low, `mem_cs_n`, `mem_wr_n` and `mem_rd_n` are 1, `mem_dq_en`, `busy` and `done` are 0, and the latched address and data outputs are 0.
- R2: When `req_valid` is 1 at a rising edge with `busy` at 0, then after that edge `mem_cs_n` and `mem_wr_n` are both 0, `busy` is 1, `mem_addr` equals the requested address and `mem_dq` equals the requested data.
- R3: A `req_valid` that is sampled while `busy` is 1 is ignored: `mem_addr` and `mem_dq` keep the accepted values and the cycle timing is unchanged.
- R4: The terminating strobe stays low for LOW cycles. It is `mem_wr_n` when `END_ON_CS` is 0 and `mem_cs_n` when it is 1. The other strobe rises exactly one cycle after the terminating strobe. The two strobes never rise on the same edge.
- R5: `mem_dq_en` rises one cycle after `mem_wr_n` falls and stays high until one cycle after the terminating edge. It is high only in cycles 1 to LOW of the write, where cycle 0 is the first cycle after acceptance.
- R6: `mem_rd_n` is 1 in every cycle.
- R7: `mem_addr` does not change while `busy` is 1. Chip-select is low only while `busy` is 1.
- R8: `busy` stays high for BUSY cycles. In the first cycle after those, `busy` is 0 and `done` is 1 for exactly one cycle. The next request is accepted no earlier than the edge after that, so address changes are at least BUSY+1 cycles apart.
- R9: With cyc(t) = ceil(t / period), LOW = max(cyc(tCS), cyc(tAddr), cyc(tPulse), cyc(tData)+1) and BUSY = max(LOW+1, cyc(tCycle)-1). The fast grade uses 25/15/15/15/12 ns for cycle, chip-select-to-end, address-to-end, strobe pulse and data-to-end. At a 20 ns period this gives LOW=2 and BUSY=3.
- R10: `SLOW_GRADE`=1 uses 45/35/25/25/20 ns for the same five intervals. At a 10 ns period this gives LOW=4 and BUSY=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Write request, sampled when busy is low |
| req_addr | input | ADDR_W | Write address |
| req_data | input | DATA_W | Write data |
| busy | output | 1 | A write cycle is in progress |
| done | output | 1 | One-cycle pulse after a cycle completes |
| mem_addr | output | ADDR_W | Address pins |
| mem_cs_n | output | 1 | Chip-select, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_rd_n | output | 1 | Output enable of the memory, active low |
| mem_dq | output | DATA_W | Outgoing data |
| mem_dq_en | output | 1 | Data driver enable |

## Verification
A corrupted cycle counter shows up at once as a strobe rising on the wrong edge. It also shifts the window of the data driver enable against the terminating edge and moves the `done` pulse. The per-cycle comparison reports this within the cycle in which the counter diverges. A wrong acceptance decision appears on the next edge as a changed address or data under `busy`, or as a strobe falling outside a cycle. The bench runs a fast grade that ends on the write strobe and a slow grade that ends on chip-select. Both variants are therefore compared pin by pin in every cycle.

// File: rtl/sramw_pkg.sv
package sramw_pkg;

   typedef enum logic [2:0] {
      TM_CYCLE,
      TM_CS_END,
      TM_ADDR_END,
      TM_PULSE,
      TM_DATA_END
   } tmin_e;

   // minimum interval in picoseconds for each speed grade
   function automatic int min_ps(input bit slow, input tmin_e which);
      int v;
      case (which)
         TM_CYCLE:    v = slow ? 45000 : 25000;
         TM_CS_END:   v = slow ? 35000 : 15000;
         TM_ADDR_END: v = slow ? 25000 : 15000;
         TM_PULSE:    v = slow ? 25000 : 15000;
         default:     v = slow ? 20000 : 12000;
      endcase
      return v;
   endfunction

   function automatic int cyc_up(input int ps, input int period_ps);
      return (ps + period_ps - 1) / period_ps;
   endfunction

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // cycles both strobes overlap before the terminating edge
   function automatic int low_cycles(input bit slow, input int period_ps);
      int l;
      l = cyc_up(min_ps(slow, TM_CS_END), period_ps);
      l = max2(l, cyc_up(min_ps(slow, TM_ADDR_END), period_ps));
      l = max2(l, cyc_up(min_ps(slow, TM_PULSE), period_ps));
      l = max2(l, cyc_up(min_ps(slow, TM_DATA_END), period_ps) + 1);
      return l;
   endfunction

   // cycles the sequencer stays busy after accepting a request
   function automatic int busy_cycles(input bit slow, input int period_ps);
      return max2(low_cycles(slow, period_ps) + 1,
                  cyc_up(min_ps(slow, TM_CYCLE), period_ps) - 1);
   endfunction

endpackage

// File: rtl/sramw_seq.sv
module sramw_seq #(
   parameter int BUSY_CYC = 3,
   parameter int CW       = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   output logic          accept,
   output logic          act_nxt,
   output logic [CW-1:0] cnt_nxt,
   output logic          busy,
   output logic          done
);

   logic          act_q;
   logic [CW-1:0] cnt_q;
   logic          fin;

   assign accept = !act_q && req_valid;
   assign busy   = act_q;

   always_comb begin
      act_nxt = act_q;
      cnt_nxt = cnt_q;
      fin     = 1'b0;
      if (accept) begin
         act_nxt = 1'b1;
         cnt_nxt = '0;
      end else if (act_q) begin
         if (cnt_q == CW'(BUSY_CYC - 1)) begin
            act_nxt = 1'b0;
            cnt_nxt = '0;
            fin     = 1'b1;
         end else begin
            cnt_nxt = cnt_q + CW'(1);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q <= 1'b0;
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         act_q <= act_nxt;
         cnt_q <= cnt_nxt;
         done  <= fin;
      end
   end

   // R8: completion pulse lasts one cycle and coincides with idle
   a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

endmodule

// File: rtl/sramw_hold.sv
module sramw_hold #(
   parameter int ADDR_W = 15,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic [ADDR_W-1:0] addr_q,
   output logic [DATA_W-1:0] data_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         data_q <= '0;
      end else if (accept) begin
         addr_q <= req_addr;
         data_q <= req_data;
      end
   end

endmodule

// File: rtl/sramw_pins.sv
module sramw_pins #(
   parameter int LOW_CYC   = 2,
   parameter int CW        = 2,
   parameter bit END_ON_CS = 1'b0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_nxt,
   input  logic [CW-1:0] cnt_nxt,
   output logic          cs_n,
   output logic          wr_n,
   output logic          dq_en
);

   logic cs_low_nxt;
   logic wr_low_nxt;
   logic en_nxt;

   generate
      if (END_ON_CS) begin : g_end_cs
         // chip-select terminates, write strobe follows one cycle later
         assign cs_low_nxt = act_nxt && (cnt_nxt < CW'(LOW_CYC));
         assign wr_low_nxt = act_nxt && (cnt_nxt < CW'(LOW_CYC + 1));
         a_r4_cs_first: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(cs_n) |-> !wr_n);
      end else begin : g_end_wr
         // write strobe terminates, chip-select follows one cycle later
         assign wr_low_nxt = act_nxt && (cnt_nxt < CW'(LOW_CYC));
         assign cs_low_nxt = act_nxt && (cnt_nxt < CW'(LOW_CYC + 1));
         a_r4_wr_first: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(wr_n) |-> !cs_n);
      end
   endgenerate

   assign en_nxt = act_nxt && (cnt_nxt != '0) && (cnt_nxt <= CW'(LOW_CYC));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_n  <= 1'b1;
         wr_n  <= 1'b1;
         dq_en <= 1'b0;
      end else begin
         cs_n  <= !cs_low_nxt;
         wr_n  <= !wr_low_nxt;
         dq_en <= en_nxt;
      end
   end

   // R4: the two strobes never rise together
   a_r4_no_joint_rise: assert property (@(posedge clk) disable iff (!rst_n)
      !($rose(cs_n) && $rose(wr_n)));
   // R5: drivers on only after the write strobe has been low a cycle
   a_r5_drive_after_wr: assert property (@(posedge clk) disable iff (!rst_n)
      dq_en |-> $past(!wr_n));

endmodule

// File: rtl/sramw_wr.sv
module sramw_wr #(
   parameter int ADDR_W        = 15,
   parameter int DATA_W        = 8,
   parameter int CLK_PERIOD_PS = 20000,
   parameter bit SLOW_GRADE    = 1'b0,
   parameter bit END_ON_CS     = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_data,
   output logic              busy,
   output logic              done,
   output logic [ADDR_W-1:0] mem_addr,
   output logic              mem_cs_n,
   output logic              mem_wr_n,
   output logic              mem_rd_n,
   output logic [DATA_W-1:0] mem_dq,
   output logic              mem_dq_en
);

   localparam int LOW_CYC  = sramw_pkg::low_cycles(SLOW_GRADE, CLK_PERIOD_PS);
   localparam int BUSY_CYC = sramw_pkg::busy_cycles(SLOW_GRADE, CLK_PERIOD_PS);
   localparam int CW       = $clog2(BUSY_CYC + 1);

   logic          accept;
   logic          act_nxt;
   logic [CW-1:0] cnt_nxt;

   assign mem_rd_n = 1'b1;

   sramw_seq #(
      .BUSY_CYC (BUSY_CYC),
      .CW       (CW)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .accept    (accept),
      .act_nxt   (act_nxt),
      .cnt_nxt   (cnt_nxt),
      .busy      (busy),
      .done      (done)
   );

   sramw_hold #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_hold (
      .clk      (clk),
      .rst_n    (rst_n),
      .accept   (accept),
      .req_addr (req_addr),
      .req_data (req_data),
      .addr_q   (mem_addr),
      .data_q   (mem_dq)
   );

   sramw_pins #(
      .LOW_CYC   (LOW_CYC),
      .CW        (CW),
      .END_ON_CS (END_ON_CS)
   ) u_pins (
      .clk     (clk),
      .rst_n   (rst_n),
      .act_nxt (act_nxt),
      .cnt_nxt (cnt_nxt),
      .cs_n    (mem_cs_n),
      .wr_n    (mem_wr_n),
      .dq_en   (mem_dq_en)
   );

   // R7: address frozen for the whole cycle
   a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_addr));
   // R7: chip-select low only inside a cycle
   a_r7_cs_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_cs_n |-> busy);
   // R3: latched data frozen while busy
   a_r3_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mem_dq));

endmodule

// File: tb/sramw_wr_bench.sv
module sramw_wr_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [14:0] req_addr = '0;
   logic [7:0]  req_data = '0;

   logic        f_busy, f_done, f_cs, f_wr, f_rd, f_en;
   logic [14:0] f_addr;
   logic [7:0]  f_dq;
   logic        s_busy, s_done, s_cs, s_wr, s_rd, s_en;
   logic [14:0] s_addr;
   logic [7:0]  s_dq;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   sramw_wr u_sramw_wr (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_data(req_data), .busy(f_busy), .done(f_done), .mem_addr(f_addr),
      .mem_cs_n(f_cs), .mem_wr_n(f_wr), .mem_rd_n(f_rd), .mem_dq(f_dq),
      .mem_dq_en(f_en));

   sramw_wr #(.CLK_PERIOD_PS(10000), .SLOW_GRADE(1'b1), .END_ON_CS(1'b1))
   u_sramw_wr_slow (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
      .req_data(req_data), .busy(s_busy), .done(s_done), .mem_addr(s_addr),
      .mem_cs_n(s_cs), .mem_wr_n(s_wr), .mem_rd_n(s_rd), .mem_dq(s_dq),
      .mem_dq_en(s_en));

   function automatic int up(input int ns, input int per);
      return (ns + per - 1) / per;
   endfunction
   function automatic int mx(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // R9: fast grade at 20 ns; R10: slow grade at 10 ns
   int fL, fT, sL, sT;
   initial begin
      fL = mx(mx(up(15, 20), up(15, 20)), mx(up(15, 20), up(12, 20) + 1));
      fT = mx(fL + 1, up(25, 20) - 1);
      sL = mx(mx(up(35, 10), up(25, 10)), mx(up(25, 10), up(20, 10) + 1));
      sT = mx(sL + 1, up(45, 10) - 1);
   end

   // reference state: active flag, cycle index, done, latched address/data
   bit fa, fd, sa, sd;
   int fk, sk;
   logic [14:0] fla, sla;
   logic [7:0]  fld, sld;

   task automatic step(inout bit a, inout int k, inout bit d,
                       inout logic [14:0] la, inout logic [7:0] ld, input int T);
      d = 1'b0;
      if (!a) begin
         if (req_valid) begin
            a = 1'b1; k = 0; la = req_addr; ld = req_data;
         end
      end else if (k == T - 1) begin
         a = 1'b0; k = 0; d = 1'b1;
      end else begin
         k = k + 1;
      end
   endtask

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fa = 0; fd = 0; fk = 0; fla = '0; fld = '0;
         sa = 0; sd = 0; sk = 0; sla = '0; sld = '0;
      end else begin
         step(fa, fk, fd, fla, fld, fT);
         step(sa, sk, sd, sla, sld, sT);
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cmp(input string gtag, input bit a, input int k, input bit d,
                      input logic [14:0] la, input logic [7:0] ld,
                      input int ce_len, input int we_len, input int L,
                      input logic cs, input logic wr, input logic rd, input logic en,
                      input logic bsy, input logic dn,
                      input logic [14:0] ad, input logic [7:0] dq);
      string st;
      string tr;
      if (!rst_n) begin
         st = "R1"; tr = "R1";
      end else begin
         st = (a && k == 0) ? "R2" : "R4";
         tr = "R3 R7";
      end
      chk($sformatf("%s cs_n %s", st, gtag), cs, !(a && k < ce_len));
      chk($sformatf("%s wr_n %s", st, gtag), wr, !(a && k < we_len));
      chk($sformatf("%s R6 rd_n %s", rst_n ? "" : "R1", gtag), rd, 1'b1);
      chk($sformatf("%s R5 dq_en %s", rst_n ? "" : "R1", gtag), en, a && k >= 1 && k <= L);
      chk($sformatf("%s R8 busy %s", rst_n ? "" : "R1", gtag), bsy, a);
      chk($sformatf("%s R8 done %s", rst_n ? "" : "R1", gtag), dn, d);
      chk($sformatf("%s addr %s", tr, gtag), ad, la);
      chk($sformatf("%s R5 data %s", tr, gtag), dq, ld);
   endtask

   always @(negedge clk) begin
      // fast instance ends on the write strobe, slow one on chip-select
      cmp("fast R9", fa, fk, fd, fla, fld, fL + 1, fL, fL,
          f_cs, f_wr, f_rd, f_en, f_busy, f_done, f_addr, f_dq);
      cmp("slow R10", sa, sk, sd, sla, sld, sL, sL + 1, sL,
          s_cs, s_wr, s_rd, s_en, s_busy, s_done, s_addr, s_dq);
   end

   logic [15:0] lfsr = 16'hACE1;
   task automatic adv();
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
   endtask

   initial begin
      repeat (3) @(negedge clk);
      @(posedge clk); #1 rst_n = 1'b1;
      // single isolated request
      @(negedge clk); req_valid = 1; req_addr = 15'h7FFF; req_data = 8'hA5;
      @(negedge clk); req_valid = 0; req_addr = 15'h0001; req_data = 8'h11;
      repeat (8) @(negedge clk);
      // request held high, inputs change every cycle: busy holds off (R3)
      for (int i = 0; i < 40; i++) begin
         adv();
         req_valid = 1; req_addr = lfsr[14:0]; req_data = lfsr[7:0] ^ 8'h3C;
         @(negedge clk);
      end
      req_valid = 0;
      repeat (6) @(negedge clk);
      // irregular request pattern
      for (int i = 0; i < 150; i++) begin
         adv();
         req_valid = lfsr[0] & lfsr[3]; req_addr = lfsr[15:1]; req_data = lfsr[9:2];
         @(negedge clk);
      end
      // reset in the middle of a write
      req_valid = 1; req_addr = 15'h2A2A; req_data = 8'h5A;
      @(negedge clk); req_valid = 0;
      @(posedge clk); #1 rst_n = 1'b0;
      repeat (2) @(negedge clk);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk); req_valid = 1; req_addr = 15'h0000; req_data = 8'hFF;
      @(negedge clk); req_valid = 0;
      repeat (10) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule